// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs single read and write cycles on an asynchronous external device that shares sixteen lines between address and data, with a transparent address latch in front of the device. Each cycle has two parts. In the first part the sequencer puts the latchable part of the address on the shared lines and raises a latch-enable output so the latch takes it. In the second part the same lines carry data. Dedicated extension lines carry the address bits that lie above the multiplexed range.

Two bus modes are selected per request. In wide mode, sixteen data bits go with sixteen multiplexed address bits. In narrow mode, eight data bits go with twenty-four address bits. In narrow mode the latch takes address bits 23..8, and in the data part the upper byte of the lines carries address bits 7..0.

The address part has its own setup and hold counts. The data part uses a setup/strobe/hold count triple that is chosen by the direction of the cycle. A request is accepted only while the block is idle. A one-cycle completion pulse marks the end of every cycle. For reads, that pulse also marks the moment when the captured data is valid.

Top module: `muxbus_seq`

## Requirements
- R1: After reset, cs_n, re_n and we_n are 1, ale, oe_hi, oe_lo and done are 0, and a_ext is 0.
- R2: The cycle after an idle request is sampled, ale is 1 for adr_setup cycles, where a count of 0 is taken as 1. ale is 0 at all other times.
- R3: After ale falls, the shared lines keep driving the latch address with both enables on for adr_hold cycles (0 means none). Only then does the data part begin.
- R4: In wide mode (wide=1), the latch address is addr[15:0] and the data-part value is wdata[15:0].
- R5: In narrow mode (wide=0), the latch address is addr[23:8]. In the data part, ad_out[15:8] carries addr[7:0] and ad_out[7:0] carries wdata[7:0].
- R6: While cs_n is 0, a_ext carries addr with bits 15..0 cleared in wide mode or bits 23..0 cleared in narrow mode. Data written at one full address reads back only from that address.
- R7: On a write (wr=1), the data part lasts wr_setup cycles with we_n=1, then max(wr_strobe,1) cycles with we_n=0, then wr_hold cycles. Both enables are on throughout. re_n stays 1.
- R8: On a read (wr=0), the same phasing uses rd_setup, rd_strobe and rd_hold with re_n low and we_n at 1. oe_lo is 0 in the data part. oe_hi is 0 in wide mode and 1 in narrow mode.
- R9: done is 1 for exactly the first idle cycle after a bus cycle. After a read, rdata holds ad_in as sampled at the end of the last strobe cycle: all sixteen bits in wide mode, or the low byte zero-extended in narrow mode.
- R10: cs_n is 0 from the first address-setup cycle through the last data-hold cycle, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a cycle (taken when idle) |
| wr | input | 1 | 1 = write, 0 = read |
| wide | input | 1 | 1 = 16-bit data mode, 0 = 8-bit data mode |
| addr | input | ADDR_W | Full address |
| wdata | input | 16 | Write data |
| adr_setup | input | CNT_W | Address setup count |
| adr_hold | input | CNT_W | Address hold count |
| rd_setup | input | CNT_W | Read setup count |
| rd_strobe | input | CNT_W | Read strobe count |
| rd_hold | input | CNT_W | Read hold count |
| wr_setup | input | CNT_W | Write setup count |
| wr_strobe | input | CNT_W | Write strobe count |
| wr_hold | input | CNT_W | Write hold count |
| ad_in | input | 16 | Shared lines as seen from the pads |
| ad_out | output | 16 | Value driven on the shared lines |
| oe_hi | output | 1 | Drive enable for ad_out[15:8] |
| oe_lo | output | 1 | Drive enable for ad_out[7:0] |
| ale | output | 1 | Address latch enable |
| cs_n | output | 1 | Chip select, active low |
| re_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| a_ext | output | ADDR_W | Extension address lines |
| rdata | output | 16 | Captured read data |
| done | output | 1 | Cycle completion pulse |

## Verification
The bench builds the block with its defaults: ADDR_W=28 and CNT_W=4. A count width of four puts both zero counts (the forced one-cycle minimums and the skipped hold phases) and the all-ones value of 15 within reach. A 28-bit address means a_ext reaches bit 27. That lets the bench write pairs of addresses that differ only in an extension bit, in both modes, and expose any aliasing in the latch split or the extension mask.

// File: rtl/muxbus_seq.sv
module muxbus_seq #(
  parameter int ADDR_W = 28,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic [CNT_W-1:0]  adr_setup,
  input  logic [CNT_W-1:0]  adr_hold,
  input  logic [CNT_W-1:0]  rd_setup,
  input  logic [CNT_W-1:0]  rd_strobe,
  input  logic [CNT_W-1:0]  rd_hold,
  input  logic [CNT_W-1:0]  wr_setup,
  input  logic [CNT_W-1:0]  wr_strobe,
  input  logic [CNT_W-1:0]  wr_hold,
  input  logic [15:0]       ad_in,
  output logic [15:0]       ad_out,
  output logic              oe_hi,
  output logic              oe_lo,
  output logic              ale,
  output logic              cs_n,
  output logic              re_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] a_ext,
  output logic [15:0]       rdata,
  output logic              done
);

  localparam logic [ADDR_W-1:0] MASK_W = {{(ADDR_W-16){1'b1}}, 16'h0000};
  localparam logic [ADDR_W-1:0] MASK_N = {{(ADDR_W-24){1'b1}}, 24'h000000};

  typedef enum logic [2:0] {PH_IDLE, PH_ASET, PH_AHLD, PH_DSET, PH_STRB, PH_DHLD} phase_t;

  phase_t            ph;
  logic [CNT_W-1:0]  cnt, t_ahold, t_dset, t_strb, t_dhold;
  logic              t_wr, t_wide;
  logic [ADDR_W-1:0] t_addr;
  logic [15:0]       t_wdata;

  wire [CNT_W-1:0] sel_set = wr ? wr_setup  : rd_setup;
  wire [CNT_W-1:0] sel_stb = wr ? wr_strobe : rd_strobe;
  wire [CNT_W-1:0] sel_hld = wr ? wr_hold   : rd_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      t_ahold <= '0;
      t_dset  <= '0;
      t_strb  <= '0;
      t_dhold <= '0;
      t_wr    <= 1'b0;
      t_wide  <= 1'b0;
      t_addr  <= '0;
      t_wdata <= '0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ph == PH_IDLE) begin
        if (req) begin
          t_wr    <= wr;
          t_wide  <= wide;
          t_addr  <= addr;
          t_wdata <= wdata;
          t_ahold <= adr_hold;
          t_dset  <= sel_set;
          t_strb  <= (sel_stb == '0) ? CNT_W'(1) : sel_stb;
          t_dhold <= sel_hld;
          cnt     <= (adr_setup == '0) ? '0 : adr_setup - 1'b1;
          ph      <= PH_ASET;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        unique case (ph)
          PH_ASET: begin
            if (t_ahold != '0) begin
              ph  <= PH_AHLD;
              cnt <= t_ahold - 1'b1;
            end else if (t_dset != '0) begin
              ph  <= PH_DSET;
              cnt <= t_dset - 1'b1;
            end else begin
              ph  <= PH_STRB;
              cnt <= t_strb - 1'b1;
            end
          end
          PH_AHLD: begin
            if (t_dset != '0) begin
              ph  <= PH_DSET;
              cnt <= t_dset - 1'b1;
            end else begin
              ph  <= PH_STRB;
              cnt <= t_strb - 1'b1;
            end
          end
          PH_DSET: begin
            ph  <= PH_STRB;
            cnt <= t_strb - 1'b1;
          end
          PH_STRB: begin
            if (!t_wr) rdata <= t_wide ? ad_in : {8'h00, ad_in[7:0]};
            if (t_dhold != '0) begin
              ph  <= PH_DHLD;
              cnt <= t_dhold - 1'b1;
            end else begin
              ph   <= PH_IDLE;
              done <= 1'b1;
            end
          end
          PH_DHLD: begin
            ph   <= PH_IDLE;
            done <= 1'b1;
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end

  wire addr_ph = (ph == PH_ASET) || (ph == PH_AHLD);
  wire data_ph = (ph == PH_DSET) || (ph == PH_STRB) || (ph == PH_DHLD);

  assign ad_out = addr_ph ? (t_wide ? t_addr[15:0] : t_addr[23:8])
                          : (t_wide ? t_wdata : {t_addr[7:0], t_wdata[7:0]});
  assign oe_hi  = addr_ph || (data_ph && (t_wr || !t_wide));
  assign oe_lo  = addr_ph || (data_ph && t_wr);
  assign ale    = (ph == PH_ASET);
  assign cs_n   = (ph == PH_IDLE);
  assign re_n   = !((ph == PH_STRB) && !t_wr);
  assign we_n   = !((ph == PH_STRB) && t_wr);
  assign a_ext  = t_addr & (t_wide ? MASK_W : MASK_N);

endmodule

// File: rtl/muxbus_seq_chk.sv
module muxbus_seq_chk #(
  parameter int ADDR_W = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              ale,
  input logic              re_n,
  input logic              we_n,
  input logic              oe_hi,
  input logic              oe_lo,
  input logic              done,
  input logic [ADDR_W-1:0] a_ext
);

  assert_ale_inside_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !cs_n);

  assert_no_ale_in_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!re_n || !we_n) |-> !ale);

  assert_write_drives_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (oe_hi && oe_lo && re_n));

  assert_read_releases_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> (!oe_lo && we_n));

  assert_done_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && $past(!cs_n)));

  assert_ext_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(a_ext));

  assert_strobe_needs_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!re_n || !we_n || oe_hi || oe_lo) |-> !cs_n);

endmodule

bind muxbus_seq muxbus_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ale(ale), .re_n(re_n), .we_n(we_n),
  .oe_hi(oe_hi), .oe_lo(oe_lo), .done(done), .a_ext(a_ext)
);

// File: tb/muxbus_seq_tb_top.sv
module muxbus_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req = 0, wr = 0, wide = 0;
  logic [27:0] addr = '0;
  logic [15:0] wdata = '0, ad_in = '0;
  logic [3:0]  adr_setup = 0, adr_hold = 0, rd_setup = 0, rd_strobe = 0, rd_hold = 0;
  logic [3:0]  wr_setup = 0, wr_strobe = 0, wr_hold = 0;
  logic [15:0] ad_out, rdata;
  logic        oe_hi, oe_lo, ale, cs_n, re_n, we_n, done;
  logic [27:0] a_ext;

  muxbus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .wide(wide), .addr(addr), .wdata(wdata),
    .adr_setup(adr_setup), .adr_hold(adr_hold), .rd_setup(rd_setup), .rd_strobe(rd_strobe),
    .rd_hold(rd_hold), .wr_setup(wr_setup), .wr_strobe(wr_strobe), .wr_hold(wr_hold),
    .ad_in(ad_in), .ad_out(ad_out), .oe_hi(oe_hi), .oe_lo(oe_lo), .ale(ale), .cs_n(cs_n),
    .re_n(re_n), .we_n(we_n), .a_ext(a_ext), .rdata(rdata), .done(done)
  );

  int n_cmp = 0, n_bad = 0;
  logic [22:0] expq[$];
  logic [27:0] exp_ext;
  logic        mon_en = 0;

  logic [15:0] lat;
  always_latch if (ale) lat = ad_out;

  logic [15:0] mem16[int];
  logic [7:0]  mem8[int];
  logic [15:0] gold16[int];
  logic [7:0]  gold8[int];

  task automatic chk(string tag, logic [27:0] act, logic [27:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int full_addr();
    if (wide) return int'({a_ext[27:16], lat});
    return int'({a_ext[27:24], lat, ad_out[15:8]});
  endfunction

  always @(negedge clk) begin
    if (rst_n && !cs_n && !we_n) begin
      if (wide) mem16[full_addr()] = ad_out;
      else      mem8[full_addr()]  = ad_out[7:0];
    end
    if (rst_n && !cs_n && !re_n) begin
      if (wide) ad_in = mem16.exists(full_addr()) ? mem16[full_addr()] : 16'hDEAD;
      else      ad_in = {ad_out[15:8], mem8.exists(full_addr()) ? mem8[full_addr()] : 8'hEE};
    end else ad_in = 16'h0000;
  end

  always @(negedge clk) begin
    if (mon_en) begin
      logic [22:0] e;
      e = (expq.size() > 0) ? expq.pop_front() : {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0, 1'b0};
      chk("R10 cs_n", 28'(cs_n), 28'(e[22]));
      chk("R2 ale", 28'(ale), 28'(e[21]));
      chk("R8 re_n", 28'(re_n), 28'(e[20]));
      chk("R7 we_n", 28'(we_n), 28'(e[19]));
      chk("R8 oe_hi", 28'(oe_hi), 28'(e[18]));
      chk("R8 oe_lo", 28'(oe_lo), 28'(e[17]));
      if (e[18]) chk("R3/R4/R5 ad_out[15:8]", 28'(ad_out[15:8]), 28'(e[16:9]));
      if (e[17]) chk("R3/R4/R5 ad_out[7:0]", 28'(ad_out[7:0]), 28'(e[8:1]));
      chk("R9 done", 28'(done), 28'(e[0]));
      if (!e[22]) chk("R6 a_ext", a_ext, exp_ext);
    end
  end

  task automatic txn(bit w, bit wd, logic [27:0] a, logic [15:0] d,
                     int as, int ah, int ds, int ss, int dh);
    logic [15:0] la, dv;
    bit oh, ol;
    @(negedge clk);
    wr = w; wide = wd; addr = a; wdata = d;
    adr_setup = 4'(as); adr_hold = 4'(ah);
    if (w) begin
      wr_setup = 4'(ds); wr_strobe = 4'(ss); wr_hold = 4'(dh);
      rd_setup = 4'd15; rd_strobe = 4'd15; rd_hold = 4'd15;
    end else begin
      rd_setup = 4'(ds); rd_strobe = 4'(ss); rd_hold = 4'(dh);
      wr_setup = 4'd15; wr_strobe = 4'd15; wr_hold = 4'd15;
    end
    req = 1;
    la = wd ? a[15:0] : a[23:8];
    dv = wd ? d : {a[7:0], d[7:0]};
    oh = w || !wd;
    ol = w;
    exp_ext = wd ? {a[27:16], 16'h0} : {a[27:24], 24'h0};
    @(posedge clk);
    #1;
    for (int i = 0; i < ((as == 0) ? 1 : as); i++) expq.push_back({5'b01111, 1'b1, la, 1'b0});
    for (int i = 0; i < ah; i++) expq.push_back({5'b00111, 1'b1, la, 1'b0});
    for (int i = 0; i < ds; i++) expq.push_back({4'b0011, oh, ol, dv, 1'b0});
    for (int i = 0; i < ((ss == 0) ? 1 : ss); i++)
      expq.push_back({2'b00, w ? 1'b1 : 1'b0, w ? 1'b0 : 1'b1, oh, ol, dv, 1'b0});
    for (int i = 0; i < dh; i++) expq.push_back({4'b0011, oh, ol, dv, 1'b0});
    expq.push_back({6'b101100, 16'h0, 1'b1});
    @(negedge clk);
    req = 0;
    while (expq.size() > 0) @(negedge clk);
    @(negedge clk);
    if (w) begin
      if (wd) gold16[int'({a[27:16], a[15:0]})] = d;
      else    gold8[int'(a)] = d[7:0];
    end else begin
      if (wd) chk("R9/R6 wide readback", 28'(rdata), 28'(gold16[int'({a[27:16], a[15:0]})]));
      else    chk("R9/R6 narrow readback", 28'(rdata), 28'({8'h00, gold8[int'(a)]}));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cs_n", 28'(cs_n), 28'd1);
    chk("R1 ale", 28'(ale), 28'd0);
    chk("R1 strobes", 28'({re_n, we_n}), 28'd3);
    chk("R1 oe", 28'({oe_hi, oe_lo}), 28'd0);
    chk("R1 done", 28'(done), 28'd0);
    chk("R1 a_ext", a_ext, 28'd0);
    rst_n = 1;
    @(negedge clk);
    mon_en = 1;
    txn(1, 1, 28'h0123456, 16'hBEEF, 1, 1, 1, 2, 1);
    txn(0, 1, 28'h0123456, 16'h0000, 0, 0, 0, 0, 0);
    txn(1, 0, 28'hA5B3C7D, 16'h005A, 2, 2, 0, 1, 2);
    txn(0, 0, 28'hA5B3C7D, 16'h0000, 3, 0, 2, 3, 0);
    txn(1, 0, 28'h25B3C7D, 16'h0077, 1, 0, 1, 1, 1);
    txn(0, 0, 28'hA5B3C7D, 16'h0000, 1, 1, 1, 1, 1);
    txn(0, 0, 28'h25B3C7D, 16'h0000, 1, 1, 1, 1, 1);
    txn(1, 1, 28'h0133456, 16'h1234, 1, 0, 0, 1, 0);
    txn(0, 1, 28'h0133456, 16'h0000, 2, 1, 1, 1, 1);
    txn(0, 1, 28'h0123456, 16'h0000, 1, 0, 1, 1, 0);
    txn(1, 1, 28'hFFFFFFF, 16'hC3A5, 15, 15, 15, 15, 15);
    txn(0, 1, 28'hFFFFFFF, 16'h0000, 15, 15, 15, 15, 15);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule